// File: doc/BRIEF.md
# Receive Symbol Order Restorer

This block sits behind a 2:1 symbol deserializer in a serial receive path. Every half-rate clock it takes one word that holds two symbols: the symbol that arrived first is in the lower slot and the one that arrived second is in the upper slot. After the deserializer starts up, a chosen marker symbol can arrive in either slot. Downstream logic needs the marker in the lower slot. When the marker arrives in the upper slot, the block adds one programmable filler symbol to the stream. The marker and every symbol after it then move over by one slot, and the marker comes out in the lower slot of the next word.

A search is armed by a start event. In automatic start the event is the rising edge of the word-aligner lock input. In manual start it is the rising edge of a request input. One status output shows that the marker has come out in the lower slot since the last start event. The symbol width is a parameter: 8 bits for raw bytes, 9 bits for decoded bytes with a control flag in the MSB, or 10 bits for undecoded code groups.

Top module: `rbo_byte_order`

## Requirements
- R1: While `rst_ni` is low, `data_o` and `ordered_o` are zero.
- R2: When no filler is pending or carried, `data_o` equals the `data_i` word of the previous cycle (one register of latency).
- R3: If a search is armed, no symbol is being carried, the upper slot of `data_i` equals `pattern_i` and the lower slot does not, then the next `data_o` is {`pad_i`, lower slot of that input}.
- R4: After a filler insertion, each output word is {lower slot of the current input, upper slot of the previous input}, until the next start event.
- R5: `ordered_o` rises in the same cycle that `data_o[SYM_W-1:0]` first shows the marker after a start event. It stays high until the next start event.
- R6: A start event is a rising edge of `sync_i` when `mode_i`=0, or a rising edge of `req_i` when `mode_i`=1. The other input is ignored. On a start event the next output is the unchanged input word, `ordered_o` goes low and any carried symbol is dropped.
- R7: Only one search runs per start event. Once `ordered_o` is high, a marker in the upper slot adds no filler.
- R8: If the marker is in both slots of a word, the lower slot wins and no filler is added.
- R9: The comparison covers the full symbol width. In 9-bit use, a symbol whose lower 8 bits match but whose control flag (MSB) differs does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Start source: 0 = aligner lock, 1 = manual request |
| sync_i | input | 1 | Word aligner lock level |
| req_i | input | 1 | Manual ordering request level |
| pattern_i | input | SYM_W | Marker symbol to place in the lower slot |
| pad_i | input | SYM_W | Filler symbol to insert |
| data_i | input | 2*SYM_W | Deserialized word, earlier symbol in the low bits |
| data_o | output | 2*SYM_W | Reordered word |
| ordered_o | output | 1 | Marker seen in the lower slot since the last start |

## Verification
A wrong shift flag shows up on the very next output word as halves swapped against their input words. A wrong carry register shows up one word later as a wrong lower slot. A search state that stays armed shows a filler in the upper slot of the next word after the marker returns to the upper slot. A status flag that never clears shows `ordered_o` still high on the word after a start event. The sweeps cover the marker in each slot, at several distances from the start event, under both start sources, and report each of these faults within two words.

// File: rtl/rbo_pkg.sv
package rbo_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic {
    START_AUTO   = 1'b0,
    START_MANUAL = 1'b1
  } start_mode_e;
endpackage

// File: rtl/rbo_trigger.sv
module rbo_trigger
  import rbo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic sync_i,
  input  logic req_i,
  output logic trig_o
);
  logic sync_q, req_q;
  logic sync_rise, req_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      req_q  <= req_i;
    end
  end

  assign sync_rise = sync_i & ~sync_q;
  assign req_rise  = req_i & ~req_q;

  always_comb begin
    unique case (start_mode_e'(mode_i))
      START_MANUAL: trig_o = req_rise;
      default:      trig_o = sync_rise;
    endcase
  end
endmodule

// File: rtl/rbo_match.sv
module rbo_match
  import rbo_pkg::*;
#(
  parameter int unsigned SYM_W = 10
) (
  input  logic [LANES*SYM_W-1:0] word_i,
  input  logic [SYM_W-1:0]       pattern_i,
  output logic [LANES-1:0]       hit_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit_o[l] = (word_i[l*SYM_W +: SYM_W] == pattern_i);
  end
endmodule

// File: rtl/rbo_shifter.sv
module rbo_shifter
  import rbo_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WORD_W = LANES * SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ins_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [SYM_W-1:0]  pad_i,
  output logic [WORD_W-1:0] eff_o,
  output logic              shift_o,
  output logic [SYM_W-1:0]  hold_o,
  output logic [WORD_W-1:0] data_o
);
  logic              shift_q;
  logic [SYM_W-1:0]  hold_q;
  logic [WORD_W-1:0] out_q;
  logic [SYM_W-1:0]  in_lo, in_hi;

  assign in_lo = data_i[SYM_W-1:0];
  assign in_hi = data_i[WORD_W-1:SYM_W];
  // stream view: carried symbol precedes the current lower slot
  assign eff_o = shift_q ? {in_lo, hold_q} : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= 1'b0;
      hold_q  <= '0;
      out_q   <= '0;
    end else if (clear_i) begin
      shift_q <= 1'b0;
      hold_q  <= '0;
      out_q   <= data_i;
    end else if (ins_i) begin
      shift_q <= 1'b1;
      hold_q  <= in_hi;
      out_q   <= {pad_i, in_lo};
    end else begin
      out_q <= eff_o;
      if (shift_q) hold_q <= in_hi;
    end
  end

  assign shift_o = shift_q;
  assign hold_o  = hold_q;
  assign data_o  = out_q;
endmodule

// File: rtl/rbo_byte_order.sv
module rbo_byte_order
  import rbo_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WORD_W = LANES * SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sync_i,
  input  logic              req_i,
  input  logic [SYM_W-1:0]  pattern_i,
  input  logic [SYM_W-1:0]  pad_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              ordered_o
);
  logic              trig;
  logic              ins;
  logic              lo_hit;
  logic              shift_q;
  logic              armed_q;
  logic              ordered_q;
  logic [SYM_W-1:0]  hold_q;
  logic [WORD_W-1:0] eff_word;
  logic [LANES-1:0]  hit;

  rbo_trigger i_trigger (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .sync_i (sync_i),
    .req_i  (req_i),
    .trig_o (trig)
  );

  rbo_match #(.SYM_W(SYM_W)) i_match (
    .word_i    (eff_word),
    .pattern_i (pattern_i),
    .hit_o     (hit)
  );

  // lower slot has priority; pad only while nothing is carried
  assign lo_hit = armed_q & ~trig & hit[0];
  assign ins    = armed_q & ~trig & ~shift_q & ~hit[0] & hit[1];

  rbo_shifter #(.SYM_W(SYM_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (trig),
    .ins_i   (ins),
    .data_i  (data_i),
    .pad_i   (pad_i),
    .eff_o   (eff_word),
    .shift_o (shift_q),
    .hold_o  (hold_q),
    .data_o  (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      ordered_q <= 1'b0;
    end else if (trig) begin
      armed_q   <= 1'b1;
      ordered_q <= 1'b0;
    end else if (lo_hit) begin
      armed_q   <= 1'b0;
      ordered_q <= 1'b1;
    end
  end

  assign ordered_o = ordered_q;
endmodule

// File: rtl/rbo_checker.sv
module rbo_checker
  import rbo_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WORD_W = LANES * SYM_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig,
  input logic              ins,
  input logic              shift_q,
  input logic [SYM_W-1:0]  pattern_i,
  input logic [SYM_W-1:0]  pad_i,
  input logic [WORD_W-1:0] data_i,
  input logic [WORD_W-1:0] data_o,
  input logic              ordered_o
);
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_q && !ins) |=> data_o == $past(data_i));  // R2

  AST_PAD_INSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |=> (data_o[WORD_W-1:SYM_W] == $past(pad_i)) &&
            (data_o[SYM_W-1:0] == $past(data_i[SYM_W-1:0])));  // R3

  AST_CARRY_SYMBOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins ##1 !trig |=> data_o[SYM_W-1:0] == $past(data_i[WORD_W-1:SYM_W], 2));  // R4

  AST_ORDERED_AT_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ordered_o) |-> data_o[SYM_W-1:0] == $past(pattern_i));  // R5

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> !ordered_o && data_o == $past(data_i));  // R6
endmodule

bind rbo_byte_order rbo_checker #(.SYM_W(SYM_W)) i_rbo_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig      (trig),
  .ins       (ins),
  .shift_q   (shift_q),
  .pattern_i (pattern_i),
  .pad_i     (pad_i),
  .data_i    (data_i),
  .data_o    (data_o),
  .ordered_o (ordered_o)
);

// File: tb/test_rbo_byte_order.sv
module test_rbo_byte_order;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned SW = 9;
  localparam int unsigned WW = 2 * SW;
  localparam logic [SW-1:0] PAT  = 9'h1BC;
  localparam logic [SW-1:0] PAD  = 9'h19C;
  localparam logic [SW-1:0] NOTK = 9'h0BC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode, sync, req;
  logic [SW-1:0] pattern, pad;
  logic [WW-1:0] din, dout;
  logic          ordered;

  int unsigned checks = 0, fails = 0, cyc = 0;

  // reference state, built from the requirement text
  logic          m_sync_q, m_req_q, m_armed, m_shift, m_ord;
  logic [SW-1:0] m_hold;
  logic [WW-1:0] m_out;
  string         m_case;

  rbo_byte_order #(.SYM_W(SW)) i_rbo_byte_order (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sync_i(sync), .req_i(req),
    .pattern_i(pattern), .pad_i(pad), .data_i(din), .data_o(dout), .ordered_o(ordered)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk(1'b0, "watchdog", cyc, 50000);
      summary();
    end
  end

  function automatic logic [WW-1:0] fill(input int k);
    logic [7:0] a, b;
    a = 8'(k * 37 + 5);
    b = 8'(k * 53 + 11);
    return {1'b0, b, 1'b0, a};
  endfunction

  task automatic model_step();
    logic trig;
    logic [SW-1:0] lo, hi;
    logic was_shift;
    trig = mode ? (req & ~m_req_q) : (sync & ~m_sync_q);
    was_shift = m_shift;
    if (trig) begin
      m_out = din; m_armed = 1'b1; m_ord = 1'b0; m_shift = 1'b0; m_hold = '0;
      m_case = "R6";
    end else begin
      lo = m_shift ? m_hold : din[SW-1:0];
      hi = m_shift ? din[SW-1:0] : din[WW-1:SW];
      m_case = m_shift ? "R4" : "R2";
      if (m_armed && lo == pattern) begin
        m_armed = 1'b0; m_ord = 1'b1; m_out = {hi, lo};
        if (hi == pattern) m_case = "R8";
      end else if (m_armed && !m_shift && hi == pattern) begin
        m_out = {pad, lo}; m_shift = 1'b1; m_case = "R3";
      end else begin
        m_out = {hi, lo};
      end
      if (was_shift || m_shift) m_hold = din[WW-1:SW];
    end
    m_sync_q = sync;
    m_req_q  = req;
  endtask

  // inputs are set at negedge; model at posedge; outputs compared at the next negedge
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(dout == m_out, m_case, 32'(dout), 32'(m_out));
    chk(ordered == m_ord, "R5", 32'(ordered), 32'(m_ord));
  endtask

  task automatic fire(input logic m, input int k);
    mode = m;
    din = fill(k);
    if (m == 1'b0) begin
      sync = 1'b0; step(); sync = 1'b1; step();
    end else begin
      req = 1'b0; step(); req = 1'b1; step(); req = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; mode = 1'b0; sync = 1'b0; req = 1'b0;
    pattern = PAT; pad = PAD; din = fill(1);
    m_sync_q = 0; m_req_q = 0; m_armed = 0; m_shift = 0; m_ord = 0; m_hold = '0; m_out = '0;
    repeat (3) @(negedge clk);
    chk(dout == '0, "R1 data", 32'(dout), 0);
    chk(ordered == 1'b0, "R1 status", 32'(ordered), 0);
    rst_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int pos = 0; pos < 3; pos++) begin
        for (int d = 0; d < 4; d++) begin
          logic [WW-1:0] f, w;
          fire(1'(m), d + pos);
          for (int j = 0; j < d; j++) begin din = fill(j + 10); step(); end
          f = fill(d + 20);
          w = (pos == 0) ? {f[WW-1:SW], PAT} : (pos == 1) ? {PAT, f[SW-1:0]} : {PAT, PAT};
          din = w; step();
          if (pos == 1) begin
            chk(dout[WW-1:SW] == PAD && dout[SW-1:0] == f[SW-1:0], "R3 pad", 32'(dout), 32'({PAD, f[SW-1:0]}));
            chk(ordered == 1'b0, "R5 not yet", 32'(ordered), 0);
            din = fill(d + 30); step();
            chk(dout[SW-1:0] == PAT && ordered, "R4 carried marker", 32'(dout), 32'(PAT));
          end else begin
            chk(dout == w && ordered, (pos == 2) ? "R8 both slots" : "R2 already ordered", 32'(dout), 32'(w));
          end
          for (int j = 0; j < 3; j++) begin din = fill(j + 40); step(); end
          f = fill(d + 50);
          din = {PAT, f[SW-1:0]}; step();
          chk(dout[WW-1:SW] != PAD, "R7 no second pad", 32'(dout), 32'(PAD));
          din = fill(60); step();
          chk(dout[WW-1:SW] != PAD && ordered, "R7 still ordered", 32'(dout), 32'(PAD));
          din = fill(61); step();
        end
      end
    end

    // R6: in manual mode an aligner edge is ignored; in auto mode a request edge is ignored
    fire(1'b1, 3);
    din = {fill(70)[WW-1:SW], PAT}; step();
    sync = 1'b0; din = fill(71); step();
    sync = 1'b1; din = {PAT, fill(72)[SW-1:0]}; step();
    chk(ordered == 1'b1 && dout[WW-1:SW] == PAT, "R6 sync ignored in manual", 32'(dout), 32'(PAT));
    mode = 1'b0; sync = 1'b1;
    req = 1'b0; din = fill(73); step();
    req = 1'b1; din = {PAT, fill(74)[SW-1:0]}; step();
    chk(ordered == 1'b1 && dout[WW-1:SW] == PAT, "R6 req ignored in auto", 32'(dout), 32'(PAT));
    req = 1'b0;

    // R6: start event while a symbol is carried drops it and passes the word
    fire(1'b0, 5);
    din = {PAT, fill(75)[SW-1:0]}; step();
    din = fill(76); step();
    sync = 1'b0; din = fill(77); step();
    sync = 1'b1; din = fill(78); step();
    chk(dout == fill(78) && !ordered, "R6 restart", 32'(dout), 32'(fill(78)));

    // R9: marker byte with wrong control flag does not match
    fire(1'b0, 6);
    din = {NOTK, fill(80)[SW-1:0]}; step();
    chk(dout[WW-1:SW] == NOTK && !ordered, "R9 flag differs", 32'(dout), 32'(NOTK));
    din = {fill(81)[WW-1:SW], NOTK}; step();
    chk(!ordered, "R9 flag differs lower", 32'(ordered), 0);
    din = {fill(82)[WW-1:SW], PAT}; step();
    chk(ordered == 1'b1, "R9 full match", 32'(ordered), 1);

    // R1: reset mid-stream clears outputs
    @(negedge clk); rst_n = 1'b0; #1;
    chk(dout == '0 && !ordered, "R1 reset again", 32'(dout), 0);
    summary();
  end
endmodule